// File: doc/BRIEF.md
# Embedded-Clock Word Serializer with Sync Generator

This block turns parallel words into a single serial stream in which every word carries its own clock marks. A word is taken from `data_i` on a chosen edge of the word strobe `wclk_i`, framed with a leading 1 and a trailing 0, and shifted out one bit per cycle of the bit clock `clk_i`. A frame is 12 bits long, so the bit clock runs at twelve times the word rate. The receiving end can recover word timing from the fixed 1-to-0 step that sits between every pair of frames.

Two sync request inputs are combined with an OR. While either one is high, the block sends a training frame in place of data: six 1s followed by six 0s. A receiver can lock onto this frame quickly. Requests are only acted on at frame boundaries, so a frame that has already started is never cut short.

The output path has a driver enable and a powerdown input. After reset or after powerdown is released, the block waits 510 word periods before the output is allowed to turn on. Powerdown clears the framing state and the start-up timer at once, without waiting for a clock edge. The analog clock multiplier and the line driver are not part of this block. The bit clock is supplied from outside, and `ser_oe_o` is provided to control an external driver.

Top module: `emb_clk_serializer`

## Requirements
- R1: Each data frame is 12 bits, sent one per `clk_i` cycle. Frame bit 0 is a start bit of 1, bits 1 to 10 are the captured word least-significant bit first (frame bit k holds word bit k-1), and bit 11 is a stop bit of 0.
- R2: A frame loaded while `sync_a_i`, `sync_b_i` or both are high is a sync frame. Frame bits 0 to 5 are 1 and frame bits 6 to 11 are 0.
- R3: The sync request is sampled only at a frame boundary, and a frame that is in progress always completes in its original form. Sync frames stop at the first boundary where both requests are low.
- R4: Once the request has been seen high at 5 consecutive boundaries, word capture is frozen and `data_i` is ignored. The freeze lasts until the boundary where the request is seen low, and the first data frame after that carries the last word captured before the freeze.
- R5: When `cap_rise_i` is high, the word is captured on a rising edge of `wclk_i`; when it is low, on a falling edge. A word captured during one frame is sent in the next frame.
- R6: `ser_oe_o` is high only when `drv_en_i` is high, `pwrdn_i` is low and initialization has completed. While `ser_oe_o` is low, `ser_o` is 0.
- R7: Taking `drv_en_i` low does not stop the internal framing. When it is driven high again, output resumes on the same frame alignment with the contents that frame would have had.
- R8: After `rst_ni` or `pwrdn_i` is released, the output stays disabled for 510 word periods (6120 `clk_i` cycles). The first enabled bit is the first bit of a complete frame.
- R9: Asserting `pwrdn_i` clears the framing state and the start-up counter immediately, without waiting for a clock edge, so the full 510-period wait is repeated. The last captured word is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, twelve cycles per word |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wclk_i | input | 1 | Word strobe, sampled in the bit clock domain |
| data_i | input | 10 | Parallel word to send |
| cap_rise_i | input | 1 | Capture edge select: 1 rising, 0 falling |
| sync_a_i | input | 1 | Sync request A |
| sync_b_i | input | 1 | Sync request B |
| drv_en_i | input | 1 | Driver enable |
| pwrdn_i | input | 1 | Powerdown, active high, clears asynchronously |
| ser_o | output | 1 | Serial bit stream |
| ser_oe_o | output | 1 | Serial output enable for the external driver |

## Verification
Two pairs of events can land in the same cycle. A sync request can change in the middle of a frame while a word capture is pending, and the capture freeze can lift at the same frame boundary that loads the first data frame after sync. The bench raises the request part-way through a data frame and checks that this frame is sent unchanged and that the next frame is a sync frame. It then holds the request for seven frames, strobing one word before the freeze and a different word after it. After release, the first data frame must carry the word captured before the freeze. A short two-frame sync burst is run as a control case: there, the word strobed during the burst must appear in the frame that follows.

// File: rtl/emb_ser_pkg.sv
package emb_ser_pkg;
  typedef enum logic {
    FRM_DATA = 1'b0,
    FRM_SYNC = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/ser_word_capture.sv
module ser_word_capture #(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic              rise_sel_i,
  input  logic              freeze_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] word_o
);
  logic wclk_q;
  logic cap_edge;

  assign cap_edge = rise_sel_i ? (wclk_i & ~wclk_q) : (~wclk_i & wclk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q <= 1'b0;
      word_o <= '0;
    end else begin
      wclk_q <= wclk_i;
      if (cap_edge && !freeze_i) word_o <= data_i;
    end
  end

  assert_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_edge && !freeze_i) |=> (word_o == $past(data_i)));

  assert_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> $stable(word_o));
endmodule

// File: rtl/ser_sync_ctrl.sv
module ser_sync_ctrl #(
  parameter int SYNC_HOLD = 5
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic req_i,
  input  logic bound_i,
  output logic freeze_o
);
  localparam int CW = $clog2(SYNC_HOLD + 1);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) run_q <= '0;
    else if (bound_i) begin
      if (!req_i) run_q <= '0;
      else if (run_q != CW'(SYNC_HOLD)) run_q <= run_q + 1'b1;
    end
  end

  assign freeze_o = (run_q == CW'(SYNC_HOLD));

  assert_freeze_clear_R4: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (bound_i && !req_i) |=> !freeze_o);

  assert_run_hold_R4: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !bound_i |=> $stable(run_q));
endmodule

// File: rtl/ser_init_timer.sv
module ser_init_timer #(
  parameter int INIT_WORDS = 510
) (
  input  logic clk_i,
  input  logic clr_ni,
  input  logic bound_i,
  output logic done_o
);
  localparam int IW = $clog2(INIT_WORDS + 1);
  logic [IW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) cnt_q <= '0;
    else if (bound_i && !done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == IW'(INIT_WORDS));

  assert_init_hold_R8: assert property (@(posedge clk_i) disable iff (!clr_ni)
    done_o |=> done_o);

  assert_init_step_R8: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !bound_i |=> $stable(cnt_q));
endmodule

// File: rtl/ser_frame_shifter.sv
module ser_frame_shifter
  import emb_ser_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              clr_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              sync_req_i,
  output logic              bound_o,
  output logic              ser_bit_o
);
  localparam int FRAME_W = DATA_W + 2;
  localparam int HALF    = FRAME_W / 2;
  localparam int CW      = $clog2(FRAME_W);
  localparam logic [FRAME_W-1:0] SYNC_PAT = {{(FRAME_W-HALF){1'b0}}, {HALF{1'b1}}};

  logic [CW-1:0]      bcnt_q;
  logic [FRAME_W-1:0] sr_q;
  frame_kind_e        kind_q;

  assign bound_o   = (bcnt_q == CW'(FRAME_W - 1));
  assign ser_bit_o = sr_q[0];

  always_ff @(posedge clk_i or negedge clr_ni) begin
    if (!clr_ni) begin
      bcnt_q <= '0;
      sr_q   <= '0;
      kind_q <= FRM_DATA;
    end else if (bound_o) begin
      bcnt_q <= '0;
      if (sync_req_i) begin
        sr_q   <= SYNC_PAT;
        kind_q <= FRM_SYNC;
      end else begin
        sr_q   <= {1'b0, word_i, 1'b1};
        kind_q <= FRM_DATA;
      end
    end else begin
      bcnt_q <= bcnt_q + 1'b1;
      sr_q   <= sr_q >> 1;
    end
  end

  assert_start_bit_R1: assert property (@(posedge clk_i) disable iff (!clr_ni)
    bound_o |=> ser_bit_o);

  assert_stop_bit_R1: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (bound_o && kind_q == FRM_DATA) |-> !ser_bit_o);

  assert_sync_tail_R2: assert property (@(posedge clk_i) disable iff (!clr_ni)
    (bound_o && kind_q == FRM_SYNC) |-> !ser_bit_o);

  assert_kind_hold_R3: assert property (@(posedge clk_i) disable iff (!clr_ni)
    !bound_o |=> $stable(kind_q));
endmodule

// File: rtl/emb_clk_serializer.sv
module emb_clk_serializer #(
  parameter int DATA_W     = 10,
  parameter int INIT_WORDS = 510,
  parameter int SYNC_HOLD  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wclk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              cap_rise_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              drv_en_i,
  input  logic              pwrdn_i,
  output logic              ser_o,
  output logic              ser_oe_o
);
  logic              clr_n;
  logic              sync_req;
  logic              bound;
  logic              freeze;
  logic              init_done;
  logic              ser_bit;
  logic [DATA_W-1:0] word;

  assign clr_n    = rst_ni & ~pwrdn_i;
  assign sync_req = sync_a_i | sync_b_i;

  ser_word_capture #(.DATA_W(DATA_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wclk_i     (wclk_i),
    .rise_sel_i (cap_rise_i),
    .freeze_i   (freeze),
    .data_i     (data_i),
    .word_o     (word)
  );

  ser_sync_ctrl #(.SYNC_HOLD(SYNC_HOLD)) u_sync (
    .clk_i    (clk_i),
    .clr_ni   (clr_n),
    .req_i    (sync_req),
    .bound_i  (bound),
    .freeze_o (freeze)
  );

  ser_init_timer #(.INIT_WORDS(INIT_WORDS)) u_init (
    .clk_i   (clk_i),
    .clr_ni  (clr_n),
    .bound_i (bound),
    .done_o  (init_done)
  );

  ser_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i      (clk_i),
    .clr_ni     (clr_n),
    .word_i     (word),
    .sync_req_i (sync_req),
    .bound_o    (bound),
    .ser_bit_o  (ser_bit)
  );

  assign ser_oe_o = drv_en_i & ~pwrdn_i & init_done;
  assign ser_o    = ser_oe_o & ser_bit;

  // output turning on after start-up must begin with a frame's first bit
  assert_first_bit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni || pwrdn_i)
    ($rose(ser_oe_o) && $past(drv_en_i)) |-> ser_o);

  assert_pd_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pwrdn_i) |-> !ser_oe_o);
endmodule

// File: tb/emb_clk_serializer_bench.sv
module emb_clk_serializer_bench;
  localparam int DW = 10;
  localparam int FW = DW + 2;
  localparam int INIT_CYC = 510 * FW;
  localparam logic [FW-1:0] SYNC_EXP = 12'b000000111111;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wclk_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic          cap_rise_i = 1'b1;
  logic          sync_a_i = 1'b0;
  logic          sync_b_i = 1'b0;
  logic          drv_en_i = 1'b1;
  logic          pwrdn_i = 1'b0;
  logic          ser_o;
  logic          ser_oe_o;

  int errors = 0;
  int checks = 0;
  bit ended  = 1'b0;

  always #5 clk_i = ~clk_i;

  emb_clk_serializer u_emb_clk_serializer (
    .clk_i(clk_i), .rst_ni(rst_ni), .wclk_i(wclk_i), .data_i(data_i),
    .cap_rise_i(cap_rise_i), .sync_a_i(sync_a_i), .sync_b_i(sync_b_i),
    .drv_en_i(drv_en_i), .pwrdn_i(pwrdn_i), .ser_o(ser_o), .ser_oe_o(ser_oe_o)
  );

  function automatic logic [FW-1:0] dframe(input logic [DW-1:0] d);
    return {1'b0, d, 1'b1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // one frame: sample 12 bits, drive stimulus between samples
  task automatic run_frame(input logic [DW-1:0] d1, input logic [DW-1:0] d2, input bit cap,
                           input int sk, input logic s1, input logic s2,
                           output logic [FW-1:0] bits, output logic [FW-1:0] oes);
    for (int k = 0; k < FW; k++) begin
      @(negedge clk_i);
      bits[k] = ser_o;
      oes[k]  = ser_oe_o;
      if (k == sk) begin sync_a_i = s1; sync_b_i = s2; end
      if (k == 2) data_i = d1;
      if (k == 4 && cap) wclk_i = 1'b1;
      if (k == 6) data_i = d2;
      if (k == 8 && cap) wclk_i = 1'b0;
    end
  endtask

  task automatic frame_chk(input logic [FW-1:0] bits, input logic [FW-1:0] oes,
                           input logic [FW-1:0] eb, input logic [FW-1:0] eo, input string tag);
    chk(bits == eb, tag, bits, eb);
    chk(oes == eo, {tag, " oe"}, oes, eo);
  endtask

  task automatic wait_init(input string tag);
    bit quiet = 1'b1;
    for (int n = 1; n < INIT_CYC; n++) begin
      @(negedge clk_i);
      if (ser_oe_o || ser_o) quiet = 1'b0;
    end
    chk(quiet, tag, {11'b0, quiet}, 12'h1);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!ended) begin
      ended = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [FW-1:0] b, o;
    logic [DW-1:0] prev;
    logic [DW-1:0] wb, wc;

    // reset state
    repeat (3) @(negedge clk_i);
    chk(!ser_oe_o && !ser_o, "R6 reset quiet", {10'b0, ser_oe_o, ser_o}, 12'h0);
    rst_ni = 1'b1;

    // R8: 510 word periods before output turns on
    wait_init("R8 quiet during init");
    run_frame(10'h2A5, 10'h15A, 1'b1, -1, 1'b0, 1'b0, b, o);
    frame_chk(b, o, dframe('0), '1, "R8 first frame after init");
    prev = 10'h2A5;

    // R1/R5: full sweep, rising capture
    for (int v = 0; v < 1024; v++) begin
      run_frame(DW'(v), ~DW'(v), 1'b1, -1, 1'b0, 1'b0, b, o);
      frame_chk(b, o, dframe(prev), '1, "R1 data frame sweep");
      prev = DW'(v);
    end

    // R5: falling capture picks the later word
    cap_rise_i = 1'b0;
    for (int v = 0; v < 40; v++) begin
      logic [DW-1:0] a, c;
      a = DW'(v * 37 + 5);
      c = DW'(v * 91 + 300);
      run_frame(a, c, 1'b1, -1, 1'b0, 1'b0, b, o);
      frame_chk(b, o, dframe(prev), '1, "R5 falling edge capture");
      prev = c;
    end
    cap_rise_i = 1'b1;

    // R2/R3: each request source, mid-frame arrival, short burst
    for (int m = 1; m < 4; m++) begin
      logic [DW-1:0] x, y;
      x = DW'(m * 111);
      y = DW'(m * 222 + 1);
      run_frame(x, x, 1'b1, 6, m[0], m[1], b, o);
      frame_chk(b, o, dframe(prev), '1, "R3 frame in progress completes");
      run_frame(y, y, 1'b1, 0, 1'b0, 1'b0, b, o);
      frame_chk(b, o, SYNC_EXP, '1, "R2 sync frame");
      run_frame('0, '0, 1'b0, -1, 1'b0, 1'b0, b, o);
      frame_chk(b, o, dframe(y), '1, "R3 sync ends, word kept after short burst");
      prev = y;
    end

    // R4: long sync freezes capture
    wb = 10'h1C3;
    wc = 10'h03C;
    run_frame(10'h155, 10'h155, 1'b1, 0, 1'b1, 1'b0, b, o);
    frame_chk(b, o, dframe(prev), '1, "R4 pre-sync data");
    run_frame(wb, wb, 1'b1, -1, 1'b1, 1'b0, b, o);
    frame_chk(b, o, SYNC_EXP, '1, "R4 sync 1");
    for (int i = 0; i < 4; i++) begin
      run_frame('0, '0, 1'b0, -1, 1'b1, 1'b0, b, o);
      frame_chk(b, o, SYNC_EXP, '1, "R4 sync hold");
    end
    run_frame(wc, wc, 1'b1, -1, 1'b1, 1'b0, b, o);
    frame_chk(b, o, SYNC_EXP, '1, "R4 sync while frozen");
    run_frame('0, '0, 1'b0, 0, 1'b0, 1'b0, b, o);
    frame_chk(b, o, SYNC_EXP, '1, "R4 last sync");
    run_frame('0, '0, 1'b0, -1, 1'b0, 1'b0, b, o);
    frame_chk(b, o, dframe(wb), '1, "R4 frozen word ignored");

    // R6/R7: enable off keeps framing
    drv_en_i = 1'b0;
    run_frame(10'h2F0, 10'h2F0, 1'b1, -1, 1'b0, 1'b0, b, o);
    frame_chk(b, o, '0, '0, "R6 disabled output quiet");
    drv_en_i = 1'b1;
    run_frame('0, '0, 1'b0, -1, 1'b0, 1'b0, b, o);
    frame_chk(b, o, dframe(10'h2F0), '1, "R7 resume aligned");

    // R9: powerdown clears and restarts init
    @(negedge clk_i);
    pwrdn_i = 1'b1;
    #1;
    chk(!ser_oe_o && !ser_o, "R9 powerdown immediate", {10'b0, ser_oe_o, ser_o}, 12'h0);
    repeat (30) @(negedge clk_i);
    chk(!ser_oe_o && !ser_o, "R6 powerdown quiet", {10'b0, ser_oe_o, ser_o}, 12'h0);
    pwrdn_i = 1'b0;
    wait_init("R9 init repeated after powerdown");
    run_frame('0, '0, 1'b0, -1, 1'b0, 1'b0, b, o);
    frame_chk(b, o, dframe(10'h2F0), '1, "R9 first frame keeps word");

    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule